// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDR or DDR SDRAM device from reset to a state where ordinary accesses are legal. Once reset is released it enables the memory clock and then issues a fixed list of commands on the shared command/address pins. The list is a precharge of all banks, an extended mode write (DDR only), a mode write, a second precharge of all banks, two auto-refreshes and a final mode write. Between commands it drives NOP and counts out the programmed wait. When the list is complete it raises a done flag, which releases the access sequencer that owns the pins from then on.

The caller supplies the SDR/DDR select, the mode and extended-mode codes, and the precharge-to-active and refresh-to-active wait counts in clock cycles. Mode writes use the bank-address pins to pick the register: 00 selects the mode register and 01 selects the extended mode register. In DDR mode the first mode write sets the DLL-reset bit of the code and the final one clears it. A mode-access enable output stays high while the list runs and drops when done rises.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, cke_o is 0, cmd_o is NOP, done_o is 0 and mode_wr_en_o is 1. In the first cycle after reset is released, cke_o is 1 with cmd_o NOP, and cke_o stays 1 from then on.
- R2: The command encoding is {cs_n,ras_n,cas_n,we_n}: NOP 0111, precharge 0010, refresh 0001, mode write 0000. Each command lasts one cycle. The order is: precharge all, extended mode write (DDR only), mode write, precharge all, refresh, refresh, final mode write. The first precharge is issued two cycles after reset is released.
- R3: Every precharge-all drives ba_o = 00 and addr_o with only bit 10 set.
- R4: The extended mode write drives ba_o = 01 and addr_o = emode_val_i.
- R5: Mode writes drive ba_o = 00. The first mode write drives mode_val_i with bit 8 forced to 1 in DDR mode and forced to 0 in SDR mode. The final mode write always drives mode_val_i with bit 8 forced to 0.
- R6: The next command after a precharge comes max(t_rp_i,1) cycles after it. The next command after a refresh comes max(t_rfc_i,1) cycles after it. NOP is driven with ba_o and addr_o at 0 in the cycles between.
- R7: The next command after any mode write comes exactly 2 cycles after it.
- R8: In DDR mode, done_o rises at cycle max(final mode write + 2, first mode write + 200). In SDR mode it rises at final mode write + 2.
- R9: Once high, done_o stays high until reset, and cmd_o stays NOP.
- R10: mode_wr_en_o is the inverse of done_o, and a mode write is only issued while mode_wr_en_o is 1.
- R11: Asserting reset partway through the list returns all outputs to their reset values at once, and the list restarts from the beginning after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ddr_mode_i | input | 1 | 1 selects DDR, 0 selects SDR |
| mode_val_i | input | ADDR_W | Mode register code |
| emode_val_i | input | ADDR_W | Extended mode register code |
| t_rp_i | input | CNT_W | Precharge-to-active wait, cycles |
| t_rfc_i | input | CNT_W | Refresh-to-active wait, cycles |
| cke_o | output | 1 | Memory clock enable |
| cmd_o | output | 4 | {cs_n,ras_n,cas_n,we_n} command |
| ba_o | output | BA_W | Bank address / mode register select |
| addr_o | output | ADDR_W | Address / mode code |
| done_o | output | 1 | Initialization complete, sticky |
| mode_wr_en_o | output | 1 | Mode-access enable |

## Verification
The bench checks the wait rules at their edges. With wait counts of 0 and 1, a design that skipped the clamp would fire two commands back to back or stall. In SDR mode it uses a mode code with bit 8 already set, so a design that only ORs in the DLL-reset bit and never clears it is caught. One DDR run has refresh waits long enough that the final mode write, not the 200-cycle DLL window, sets the done time. A design that always adds the DLL window, or that picks the wrong one of the two limits, shows done in the wrong cycle. A reset in the middle of the list checks that no partial state survives: a stale step index would show up as a missing first precharge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    STP_PALL0   = 3'd0,
    STP_EMRS    = 3'd1,
    STP_MRS_DLL = 3'd2,
    STP_PALL1   = 3'd3,
    STP_REF0    = 3'd4,
    STP_REF1    = 3'd5,
    STP_MRS_FIN = 3'd6
  } step_e;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_CKE  = 3'd1,
    PH_CMD  = 3'd2,
    PH_GAP  = 3'd3,
    PH_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/sdram_init_step_dec.sv
module sdram_init_step_dec
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int CNT_W       = 8,
  parameter int AP_BIT      = 10,
  parameter int DLL_RST_BIT = 8
) (
  input  step_e              step_i,
  input  logic               ddr_i,
  input  logic [ADDR_W-1:0]  mode_i,
  input  logic [ADDR_W-1:0]  emode_i,
  input  logic [CNT_W-1:0]   t_rp_i,
  input  logic [CNT_W-1:0]   t_rfc_i,
  output cmd_e               cmd_o,
  output logic [BA_W-1:0]    ba_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [CNT_W-1:0]   gap_o,
  output step_e              next_o,
  output logic               last_o
);
  logic [CNT_W-1:0] rp_gap, rfc_gap;

  // zero wait still needs one cycle between commands
  assign rp_gap  = (t_rp_i  == '0) ? CNT_W'(1) : t_rp_i;
  assign rfc_gap = (t_rfc_i == '0) ? CNT_W'(1) : t_rfc_i;

  always_comb begin
    cmd_o  = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    gap_o  = CNT_W'(2);
    unique case (step_i)
      STP_PALL0, STP_PALL1: begin
        cmd_o          = CMD_PALL;
        addr_o[AP_BIT] = 1'b1;
        gap_o          = rp_gap;
      end
      STP_EMRS: begin
        cmd_o  = CMD_MRS;
        ba_o   = BA_W'(1);
        addr_o = emode_i;
      end
      STP_MRS_DLL: begin
        cmd_o               = CMD_MRS;
        addr_o              = mode_i;
        addr_o[DLL_RST_BIT] = ddr_i;
      end
      STP_REF0, STP_REF1: begin
        cmd_o = CMD_REF;
        gap_o = rfc_gap;
      end
      STP_MRS_FIN: begin
        cmd_o               = CMD_MRS;
        addr_o              = mode_i;
        addr_o[DLL_RST_BIT] = 1'b0;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (step_i == STP_PALL0) next_o = ddr_i ? STP_EMRS : STP_MRS_DLL;
    else if (step_i == STP_MRS_FIN) next_o = STP_MRS_FIN;
    else next_o = step_e'(step_i + 3'd1);
  end

  assign last_o = (step_i == STP_MRS_FIN);
endmodule

// File: rtl/sdram_init_dwell.sv
module sdram_init_dwell #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (load_i)          cnt_o <= val_i;
    else if (cnt_o != '0)     cnt_o <= cnt_o - W'(1);
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int CNT_W       = 8,
  parameter int AP_BIT      = 10,
  parameter int DLL_RST_BIT = 8,
  parameter int DLL_WAIT    = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ddr_mode_i,
  input  logic [ADDR_W-1:0] mode_val_i,
  input  logic [ADDR_W-1:0] emode_val_i,
  input  logic [CNT_W-1:0]  t_rp_i,
  input  logic [CNT_W-1:0]  t_rfc_i,
  output logic              cke_o,
  output logic [3:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              mode_wr_en_o
);
  localparam int DLL_W = $clog2(DLL_WAIT + 1);

  phase_e phase_q, phase_d;
  step_e  step_q, step_d, next_step;
  logic   dll_armed_q;

  cmd_e              dec_cmd;
  logic [BA_W-1:0]   dec_ba;
  logic [ADDR_W-1:0] dec_addr;
  logic [CNT_W-1:0]  dec_gap, gap_cnt;
  logic [DLL_W-1:0]  dll_cnt;
  logic              dec_last, gap_load, dll_load, adv, dll_ok;

  sdram_init_step_dec #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .AP_BIT(AP_BIT), .DLL_RST_BIT(DLL_RST_BIT)
  ) u_dec (
    .step_i (step_q),
    .ddr_i  (ddr_mode_i),
    .mode_i (mode_val_i),
    .emode_i(emode_val_i),
    .t_rp_i (t_rp_i),
    .t_rfc_i(t_rfc_i),
    .cmd_o  (dec_cmd),
    .ba_o   (dec_ba),
    .addr_o (dec_addr),
    .gap_o  (dec_gap),
    .next_o (next_step),
    .last_o (dec_last)
  );

  assign gap_load = (phase_q == PH_CMD);

  sdram_init_dwell #(.W(CNT_W)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(gap_load),
    .val_i (dec_gap - CNT_W'(1)),
    .cnt_o (gap_cnt)
  );

  assign dll_load = (phase_q == PH_CMD) && (step_q == STP_MRS_DLL) && ddr_mode_i;

  sdram_init_dwell #(.W(DLL_W)) u_dll (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(dll_load),
    .val_i (DLL_W'(DLL_WAIT - 1)),
    .cnt_o (dll_cnt)
  );

  assign dll_ok = !ddr_mode_i || (dll_armed_q && (dll_cnt <= DLL_W'(1)));

  always_comb begin
    adv = 1'b0;
    if (phase_q == PH_CMD)      adv = (dec_gap == CNT_W'(1));
    else if (phase_q == PH_GAP) adv = (gap_cnt <= CNT_W'(1));
  end

  always_comb begin
    phase_d = phase_q;
    step_d  = step_q;
    unique case (phase_q)
      PH_OFF: phase_d = PH_CKE;
      PH_CKE: begin
        phase_d = PH_CMD;
        step_d  = STP_PALL0;
      end
      PH_CMD, PH_GAP: begin
        if (!adv)          phase_d = PH_GAP;
        else if (!dec_last) begin
          phase_d = PH_CMD;
          step_d  = next_step;
        end
        else if (dll_ok)   phase_d = PH_DONE;
        else               phase_d = PH_GAP;
      end
      PH_DONE: phase_d = PH_DONE;
      default: phase_d = PH_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_OFF;
      step_q      <= STP_PALL0;
      dll_armed_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      if (dll_load) dll_armed_q <= 1'b1;
    end
  end

  assign cke_o        = (phase_q != PH_OFF);
  assign cmd_o        = (phase_q == PH_CMD) ? dec_cmd  : CMD_NOP;
  assign ba_o         = (phase_q == PH_CMD) ? dec_ba   : '0;
  assign addr_o       = (phase_q == PH_CMD) ? dec_addr : '0;
  assign done_o       = (phase_q == PH_DONE);
  assign mode_wr_en_o = (phase_q != PH_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int AP_BIT      = 10,
  parameter int DLL_RST_BIT = 8,
  parameter int DLL_WAIT    = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ddr_mode_i,
  input logic              cke_o,
  input logic [3:0]        cmd_o,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o,
  input logic              mode_wr_en_o
);
  localparam int SW = $clog2(DLL_WAIT + 1);

  logic          dll_seen;
  logic [SW-1:0] since_dll;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_seen  <= 1'b0;
      since_dll <= '0;
    end else if (ddr_mode_i && cmd_o == CMD_MRS && ba_o == '0 && addr_o[DLL_RST_BIT]) begin
      dll_seen  <= 1'b1;
      since_dll <= SW'(1);
    end else if (dll_seen && since_dll < SW'(DLL_WAIT)) begin
      since_dll <= since_dll + SW'(1);
    end
  end

  // R10
  mrs_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_MRS |-> mode_wr_en_o);

  // R10
  en_vs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_en_o != done_o);

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_o == CMD_NOP);

  // R1
  cke_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);

  // R3
  pall_ap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_PALL |-> addr_o[AP_BIT] && ba_o == '0);

  // R7
  mrs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o == CMD_MRS |=> cmd_o == CMD_NOP);

  // R8
  dll_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) && ddr_mode_i |-> dll_seen && since_dll >= SW'(DLL_WAIT));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT),
  .DLL_RST_BIT(DLL_RST_BIT), .DLL_WAIT(DLL_WAIT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ddr_mode_i  (ddr_mode_i),
  .cke_o       (cke_o),
  .cmd_o       (cmd_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .done_o      (done_o),
  .mode_wr_en_o(mode_wr_en_o)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int AW = 13;
  localparam int BW = 2;
  localparam int CW = 8;
  localparam int DLLW = 200;
  localparam logic [3:0] NOP = 4'b0111, PALL = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ddr = 1'b0;
  logic [AW-1:0] mode_v = '0, emode_v = '0;
  logic [CW-1:0] trp = '0, trfc = '0;
  logic cke, done, mwe;
  logic [3:0] cmd;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int n_chk = 0;
  int n_bad = 0;
  logic [20:0] q_vec[$];
  string q_tag[$];

  always #10 clk = ~clk;

  sdram_init_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .ddr_mode_i(ddr),
    .mode_val_i(mode_v), .emode_val_i(emode_v),
    .t_rp_i(trp), .t_rfc_i(trfc),
    .cke_o(cke), .cmd_o(cmd), .ba_o(ba), .addr_o(addr),
    .done_o(done), .mode_wr_en_o(mwe)
  );

  task automatic push(logic c, logic [3:0] k, logic [1:0] b, logic [AW-1:0] a, logic d, string t);
    q_vec.push_back({c, k, b, a, d});
    q_tag.push_back(t);
  endtask

  // fill NOPs so that the next pushed entry lands on cycle t
  task automatic pad_to(int t, string tg);
    while (q_vec.size() < t - 1) push(1'b1, NOP, 2'b00, '0, 1'b0, tg);
  endtask

  function automatic int gp(logic [CW-1:0] x);
    return (x == 0) ? 1 : int'(x);
  endfunction

  task automatic build();
    int t, m1, m2, dn;
    q_vec.delete();
    q_tag.delete();
    push(1'b1, NOP, 2'b00, '0, 1'b0, "R1");
    t = 2;
    push(1'b1, PALL, 2'b00, AW'(1) << 10, 1'b0, "R2 R3");
    t += gp(trp); pad_to(t, "R6");
    if (ddr) begin
      push(1'b1, MRS, 2'b01, emode_v, 1'b0, "R2 R4");
      t += 2; pad_to(t, "R7");
    end
    m1 = t;
    push(1'b1, MRS, 2'b00, ddr ? (mode_v | AW'(13'h100)) : (mode_v & ~AW'(13'h100)), 1'b0, "R2 R5");
    t += 2; pad_to(t, "R7");
    push(1'b1, PALL, 2'b00, AW'(1) << 10, 1'b0, "R2 R3");
    t += gp(trp); pad_to(t, "R6");
    push(1'b1, REF, 2'b00, '0, 1'b0, "R2 R6");
    t += gp(trfc); pad_to(t, "R6");
    push(1'b1, REF, 2'b00, '0, 1'b0, "R2 R6");
    t += gp(trfc); pad_to(t, "R6");
    m2 = t;
    push(1'b1, MRS, 2'b00, mode_v & ~AW'(13'h100), 1'b0, "R2 R5");
    dn = m2 + 2;
    pad_to(dn, "R7");
    if (ddr && m1 + DLLW > dn) dn = m1 + DLLW;
    pad_to(dn, "R8");
    for (int i = 0; i < 8; i++) push(1'b1, NOP, 2'b00, '0, 1'b1, "R9");
  endtask

  task automatic check_vec(logic [20:0] exp, string tg);
    logic [20:0] act;
    act = {cke, cmd, ba, addr, done};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tg, act, exp, $time);
    end
    n_chk++;
    if (mwe !== !exp[0]) begin
      n_bad++;
      $display("FAIL R10: mode_wr_en actual %b expected %b at %0t", mwe, !exp[0], $time);
    end
  endtask

  task automatic run_cfg(logic d, logic [AW-1:0] m, logic [AW-1:0] e, logic [CW-1:0] rp, logic [CW-1:0] rfc);
    @(negedge clk);
    rst_ni = 1'b0;
    ddr = d; mode_v = m; emode_v = e; trp = rp; trfc = rfc;
    build();
    @(negedge clk);
    @(negedge clk);
    check_vec({1'b0, NOP, 2'b00, {AW{1'b0}}, 1'b0}, "R1");
    rst_ni = 1'b1;
    for (int k = 1; k <= q_vec.size(); k++) begin
      @(posedge clk);
      @(negedge clk);
      check_vec(q_vec[k-1], q_tag[k-1]);
    end
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // DDR, typical waits
    run_cfg(1'b1, 13'h0023, 13'h0002, 8'd3, 8'd7);
    // SDR, same waits
    run_cfg(1'b0, 13'h0023, 13'h0002, 8'd3, 8'd7);
    // SDR, minimum gaps and mode code with bit 8 already set
    run_cfg(1'b0, 13'h1FFF, 13'h0002, 8'd0, 8'd1);
    // DDR, long refresh waits dominate the DLL window
    run_cfg(1'b1, 13'h0032, 13'h0002, 8'd2, 8'd120);
    // R11: reset partway through a DDR run
    @(negedge clk);
    rst_ni = 1'b0;
    ddr = 1'b1; mode_v = 13'h0023; emode_v = 13'h0002; trp = 8'd3; trfc = 8'd7;
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_vec({1'b0, NOP, 2'b00, {AW{1'b0}}, 1'b0}, "R11");
    // restart after the aborted run must replay the full list
    run_cfg(1'b1, 13'h0132, 13'h0000, 8'd5, 8'd9);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule